// File: doc/BRIEF.md
# Converter Configuration Word Register and Operating-Mode Controller

This block holds the configuration of a dual-channel converter. The configuration shares the channel A data bus. While an active-low write strobe is low, software or a host puts an 8-bit word on the upper eight bits of that bus. The word is captured when the strobe returns high. The strobe has no timing relationship to the conversion clock, and the conversion clock may keep running during a write. The captured word crosses into the conversion clock domain through a toggle flag and a synchronizer chain. The decoded settings change only when the synchronized update event arrives.

The word selects one of three operating modes: normal, standby and power-down, with power-down taking priority. It also selects interleaved input, an external reference and a 4-bit gain-adjust code for channel A. Returning to normal operation passes through a wake-up phase of a set number of cycles. This phase is short when leaving standby and long when leaving power-down, and a ready flag stays low until it ends. The gain code is frozen whenever a word selects standby or power-down.

Top module: `dacctl_mode_ctrl`

## Requirements
- R1: After reset the block is in normal operation with `out_ready`=1, `pwr_down`=0, `standby`=0, `ilv_en`=0, `ref_ext`=0 and `gain_code`=4'b1000 (the 0 dB code).
- R2: The word is `port_a[9:2]`: bit 9 power-down request, bit 8 converter enable, bit 7 interleave select, bit 6 external reference select, bits 5:2 gain code with bit 5 as MSB. Bits 1:0 have no effect.
- R3: The word is captured only on the rising edge of `wr_strobe_n`. Changing `port_a` while the strobe stays high changes no output.
- R4: Decoded outputs change on the third rising edge of `clk` after the strobe rising edge, and not before it.
- R5: A word with bit 9 set puts the block in power-down (`pwr_down`=1, `out_ready`=0), whatever the enable bit holds.
- R6: A word with bits 9 and 8 both clear puts the block in standby (`standby`=1, `out_ready`=0).
- R7: A word selecting normal operation while in standby raises `out_ready` exactly STBY_WAKE_CYC clock cycles after the mode update.
- R8: A word selecting normal operation while in power-down raises `out_ready` exactly PD_WAKE_CYC clock cycles after the mode update.
- R9: During a wake-up countdown, a further word selecting normal operation lets the running countdown continue unchanged. A word selecting standby or power-down cancels the countdown and enters that mode.
- R10: `ilv_en` follows bit 7 and `ref_ext` follows bit 6 of every applied word, in every mode.
- R11: `gain_code` takes the word's gain field only when the word selects normal operation. Words selecting standby or power-down leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| port_a | input | 10 | Channel A data bus carrying the configuration word in bits 9:2 |
| wr_strobe_n | input | 1 | Active-low write strobe; word captured on its rising edge |
| pwr_down | output | 1 | Block is in power-down |
| standby | output | 1 | Block is in standby |
| ilv_en | output | 1 | Interleaved input mode selected |
| ref_ext | output | 1 | External reference selected (0 = internal) |
| gain_code | output | 4 | Channel A gain-adjust code |
| out_ready | output | 1 | Normal operation reached and output valid |

## Verification
A lost or doubled update event shows at the ports three cycles after a strobe. The decoded fields either fail to move or move at the wrong edge. A wake counter loaded with the wrong latency, or not cancelled, shows as `out_ready` rising one or more cycles early or late. It can also rise while `pwr_down` is still expected. The bench samples the cycle just before and the cycle of the expected rise. A gain register that is wrongly written in a low-power mode shows immediately on `gain_code` at the same update edge.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;

   // Operating states of the mode controller
   typedef enum logic [1:0] {
      MD_RUN  = 2'd0,
      MD_STBY = 2'd1,
      MD_OFF  = 2'd2,
      MD_WAKE = 2'd3
   } md_e;

   // Target mode chosen by a configuration word: power-down wins over standby
   function automatic md_e target_mode(input logic pd_req, input logic en_req);
      if (pd_req)       return MD_OFF;
      else if (!en_req) return MD_STBY;
      else              return MD_RUN;
   endfunction

endpackage

// File: rtl/dacctl_capture.sv
module dacctl_capture #(
   parameter int          BUS_W    = 10,
   parameter int          CW       = 8,
   parameter logic [CW-1:0] RST_WORD = '0
) (
   input  logic             rst_n,
   input  logic             wr_strobe_n,
   input  logic [BUS_W-1:0] port_a,
   output logic [CW-1:0]    word_o,
   output logic             tgl_o
);

   if (CW > BUS_W) begin : g_bad_width
      $error("dacctl_capture: word wider than bus");
   end

   // Strobe-domain capture: word and toggle flag change together
   always_ff @(posedge wr_strobe_n or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= RST_WORD;
         tgl_o  <= 1'b0;
      end else begin
         word_o <= port_a[BUS_W-1 -: CW];
         tgl_o  <= ~tgl_o;
      end
   end

   AST_BUS_KNOWN: assert property (@(posedge wr_strobe_n) disable iff (!rst_n)
      !$isunknown(port_a)) else $error("bus unknown at strobe"); // R3

endmodule

// File: rtl/dacctl_sync.sv
module dacctl_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_async,
   output logic upd_o
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("dacctl_sync: at least two synchronizer stages needed");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   seen_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= tgl_async;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= chain_q[SYNC_STAGES-1];

   assign upd_o = chain_q[SYNC_STAGES-1] ^ seen_q;

   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o && $stable(tgl_async) |=> !upd_o) else $error("update not a single pulse"); // R4

endmodule

// File: rtl/dacctl_fsm.sv
module dacctl_fsm
   import dacctl_pkg::*;
#(
   parameter int                 GAIN_W        = 4,
   parameter int                 STBY_WAKE_CYC = 375,
   parameter int                 PD_WAKE_CYC   = 62500,
   parameter logic [GAIN_W-1:0]  GAIN_RST      = 4'b1000,
   localparam int                CW            = GAIN_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_i,
   input  logic [CW-1:0]     word_i,
   output md_e               st_o,
   output logic              ilv_o,
   output logic              ref_o,
   output logic [GAIN_W-1:0] gain_o
);

   localparam int MAX_WAKE = (STBY_WAKE_CYC > PD_WAKE_CYC) ? STBY_WAKE_CYC : PD_WAKE_CYC;
   localparam int CNT_W    = $clog2(MAX_WAKE + 1);

   if (STBY_WAKE_CYC < 1 || PD_WAKE_CYC < 1) begin : g_bad_wake
      $error("dacctl_fsm: wake-up counts must be at least one");
   end

   // Field positions inside the captured word
   logic              w_pd, w_en, w_ilv, w_ref;
   logic [GAIN_W-1:0] w_gain;
   assign w_pd   = word_i[CW-1];
   assign w_en   = word_i[CW-2];
   assign w_ilv  = word_i[CW-3];
   assign w_ref  = word_i[CW-4];
   assign w_gain = word_i[GAIN_W-1:0];

   md_e              st_q, st_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;

   always_comb begin
      st_n  = st_q;
      cnt_n = cnt_q;
      // Countdown toward normal operation
      if (st_q == MD_WAKE) begin
         if (cnt_q <= CNT_W'(1)) begin
            st_n  = MD_RUN;
            cnt_n = '0;
         end else begin
            cnt_n = cnt_q - CNT_W'(1);
         end
      end
      // A new word overrides the countdown when it asks for a low-power mode
      if (upd_i) begin
         case (target_mode(w_pd, w_en))
            MD_OFF:  begin st_n = MD_OFF;  cnt_n = '0; end
            MD_STBY: begin st_n = MD_STBY; cnt_n = '0; end
            default: begin
               if (st_q == MD_STBY) begin
                  st_n  = MD_WAKE;
                  cnt_n = CNT_W'(STBY_WAKE_CYC);
               end else if (st_q == MD_OFF) begin
                  st_n  = MD_WAKE;
                  cnt_n = CNT_W'(PD_WAKE_CYC);
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= MD_RUN;
         cnt_q  <= '0;
         ilv_o  <= 1'b0;
         ref_o  <= 1'b0;
         gain_o <= GAIN_RST;
      end else begin
         st_q  <= st_n;
         cnt_q <= cnt_n;
         if (upd_i) begin
            ilv_o <= w_ilv;
            ref_o <= w_ref;
            if (!w_pd && w_en) gain_o <= w_gain;
         end
      end
   end

   assign st_o = st_q;

   AST_PD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i && w_pd |=> st_q == MD_OFF) else $error("power-down not taken"); // R5
   AST_STBY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i && !w_pd && !w_en |=> st_q == MD_STBY) else $error("standby not taken"); // R6
   AST_WAKE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == MD_WAKE |-> cnt_q != '0 && cnt_q <= CNT_W'(MAX_WAKE)) else $error("wake count out of range"); // R7
   AST_WAKE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == MD_WAKE && cnt_q > CNT_W'(1) && upd_i && !w_pd && w_en |=> st_q == MD_WAKE && cnt_q == $past(cnt_q) - CNT_W'(1))
      else $error("countdown restarted"); // R9
   AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == MD_STBY || st_q == MD_OFF) && !upd_i |=> $stable(gain_o)) else $error("gain moved in low power"); // R11
   AST_LOWPWR_STAY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == MD_STBY || st_q == MD_OFF) && !upd_i |=> $stable(st_q)) else $error("left low power without a word"); // R8

endmodule

// File: rtl/dacctl_mode_ctrl.sv
module dacctl_mode_ctrl
   import dacctl_pkg::*;
#(
   parameter int BUS_W         = 10,
   parameter int GAIN_W        = 4,
   parameter int SYNC_STAGES   = 2,
   parameter int STBY_WAKE_CYC = 375,
   parameter int PD_WAKE_CYC   = 62500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_W-1:0]  port_a,
   input  logic              wr_strobe_n,
   output logic              pwr_down,
   output logic              standby,
   output logic              ilv_en,
   output logic              ref_ext,
   output logic [GAIN_W-1:0] gain_code,
   output logic              out_ready
);

   localparam int                CW       = GAIN_W + 4;
   localparam logic [GAIN_W-1:0] GAIN_0DB = {1'b1, {(GAIN_W-1){1'b0}}};
   // Reset word: enabled, not interleaved, internal reference, 0 dB
   localparam logic [CW-1:0]     RST_WORD = {4'b0100, GAIN_0DB};

   if (BUS_W < CW) begin : g_bad_bus
      $error("dacctl_mode_ctrl: bus too narrow for the configuration word");
   end

   logic [CW-1:0] word_async;
   logic          tgl_async;
   logic          upd;
   md_e           st;

   dacctl_capture #(.BUS_W(BUS_W), .CW(CW), .RST_WORD(RST_WORD)) i_capture (
      .rst_n       (rst_n),
      .wr_strobe_n (wr_strobe_n),
      .port_a      (port_a),
      .word_o      (word_async),
      .tgl_o       (tgl_async)
   );

   dacctl_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .tgl_async (tgl_async),
      .upd_o     (upd)
   );

   dacctl_fsm #(
      .GAIN_W        (GAIN_W),
      .STBY_WAKE_CYC (STBY_WAKE_CYC),
      .PD_WAKE_CYC   (PD_WAKE_CYC),
      .GAIN_RST      (GAIN_0DB)
   ) i_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_i  (upd),
      .word_i (word_async),
      .st_o   (st),
      .ilv_o  (ilv_en),
      .ref_o  (ref_ext),
      .gain_o (gain_code)
   );

   assign pwr_down  = (st == MD_OFF);
   assign standby   = (st == MD_STBY);
   assign out_ready = (st == MD_RUN);

   AST_READY_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_ready) |-> $past(st) == MD_WAKE) else $error("ready without wake-up"); // R7
   AST_NO_SETTING_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(ilv_en) && $stable(ref_ext)) else $error("setting moved without update"); // R10

endmodule

// File: tb/test_dacctl_mode_ctrl.sv
module test_dacctl_mode_ctrl;

   localparam int SW = 6;
   localparam int PW = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] port_a = '0;
   logic       wr_strobe_n = 1'b1;
   logic       pwr_down, standby, ilv_en, ref_ext, out_ready;
   logic [3:0] gain_code;

   dacctl_mode_ctrl #(.STBY_WAKE_CYC(SW), .PD_WAKE_CYC(PW)) i_dacctl_mode_ctrl (
      .clk, .rst_n, .port_a, .wr_strobe_n,
      .pwr_down, .standby, .ilv_en, .ref_ext, .gain_code, .out_ready
   );

   always #4 clk = ~clk;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // Expected-state image: {pd, stby, ilv, ref, rdy, gain}
   logic e_pd, e_sb, e_ilv, e_ref, e_rdy;
   logic [3:0] e_gain;

   typedef struct {
      int         at;
      logic [8:0] v;
      string      tag;
   } item_t;
   item_t sb_q[$];

   task automatic push(input int at, input string tag);
      item_t it;
      it.at = at;
      it.v = {e_pd, e_sb, e_ilv, e_ref, e_rdy, e_gain};
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   // Monitor: compare scheduled expectations at the falling edge
   always @(negedge clk) begin
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
         if (sb_q[i].at == cyc) begin
            logic [8:0] act;
            act = {pwr_down, standby, ilv_en, ref_ext, out_ready, gain_code};
            checks++;
            if (act !== sb_q[i].v) begin
               errors++;
               $display("FAIL %s cyc %0d actual %b expected %b", sb_q[i].tag, cyc, act, sb_q[i].v);
            end
            sb_q.delete(i);
         end
      end
   end

   task automatic wr(input logic [9:0] w, output int t);
      @(negedge clk); port_a = w; wr_strobe_n = 1'b0;
      @(negedge clk); wr_strobe_n = 1'b1; t = cyc;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int t, ta, tb, tc, td;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 defaults
      e_pd = 0; e_sb = 0; e_ilv = 0; e_ref = 0; e_rdy = 1; e_gain = 4'b1000;
      push(cyc + 1, "R1");
      wait_until(cyc + 3);

      // R2/R10/R4: normal, interleave, external ref, gain 0011, low bits set
      wr(10'b0111001111, t);
      push(t + 2, "R4");
      e_ilv = 1; e_ref = 1; e_gain = 4'b0011;
      push(t + 3, "R2");
      wait_until(t + 4);
      port_a = 10'b1000000011;            // R3: no strobe
      push(t + 8, "R3");
      wait_until(t + 9);

      // R6/R11: standby word with a new gain that must be ignored
      wr(10'b0000010100, t);
      e_sb = 0; e_rdy = 1; push(t + 2, "R4");
      e_sb = 1; e_rdy = 0; e_ilv = 0; e_ref = 0;
      push(t + 3, "R6");
      wait_until(t + 5);

      // R7: back to normal from standby
      wr(10'b0100011000, t);
      e_sb = 0; e_gain = 4'b0110;
      push(t + 3, "R11");
      push(t + 3 + SW - 1, "R7");
      e_rdy = 1;
      push(t + 3 + SW, "R7");
      wait_until(t + 4 + SW);

      // R5: power-down with enable bit also set
      wr(10'b1100111100, t);
      e_pd = 1; e_rdy = 0;
      push(t + 3, "R5");
      wait_until(t + 5);

      // R8: back to normal from power-down
      wr(10'b0100100000, t);
      e_pd = 0; e_gain = 4'b1000;
      push(t + 3, "R8");
      push(t + 3 + PW - 1, "R8");
      e_rdy = 1;
      push(t + 3 + PW, "R8");
      wait_until(t + 4 + PW);

      // R9: second normal word during power-down wake keeps the countdown
      wr(10'b1000000000, t);
      e_pd = 1; e_rdy = 0;
      push(t + 3, "R5");
      wait_until(t + 5);
      wr(10'b0100000100, ta);
      wait_until(ta + 6);
      wr(10'b0100001000, tb);
      e_pd = 0; e_gain = 4'b0010;
      push(tb + 3, "R9");
      push(ta + 3 + PW - 1, "R9");
      e_rdy = 1;
      push(ta + 3 + PW, "R9");
      wait_until(ta + 4 + PW);

      // R9: power-down word cancels a standby wake
      wr(10'b0000000000, t);
      e_sb = 1; e_rdy = 0;
      push(t + 3, "R6");
      wait_until(t + 5);
      wr(10'b0100010000, tc);
      wait_until(tc + 3);
      wr(10'b1000111100, td);
      e_sb = 0; e_pd = 1; e_gain = 4'b0100;
      push(td + 3, "R9");
      push(tc + 3 + SW + 4, "R9");
      wait_until(tc + 3 + SW + 6);

      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard left %0d items", sb_q.size());
      end
      finish_run();
   end

endmodule